// File: doc/BRIEF.md
# Memory Write Protect Controller

This block decides whether each write request may proceed. Requests go either to a memory array or to a small register space. A 2-bit protection code chooses how much of the array, counted up from address zero, refuses writes. A one-way lock bit seals a fixed window of register addresses. Once the lock bit is 1, it can only be cleared by reset. Reset stands in for the nonvolatile storage that a real device would use for these bits.

Each request is presented for one clock with its space, address and data. On the next cycle the block gives exactly one result:
- a one-cycle array write enable,
- a one-cycle register write enable, or
- a one-cycle reject pulse.

The registered address and data go with an accepted write. Both the protection code and the lock bit live in a control register inside the register space. Writes to that control register are always accepted. The current configuration is visible on output ports.

Top module: `wp_guard_ctrl`

## Requirements
- R1: Each cycle with `req_valid`=1 produces, one clock later, exactly one single-cycle pulse among `arr_we`, `reg_we` and `wr_reject`. A cycle without a request produces none of them. A rejected write raises no enable and changes no configuration.
- R2: With protection code 00, every array address is writable.
- R3: With code 01, array addresses whose top two bits are 00 (the lowest quarter) are rejected, and all others are accepted.
- R4: With code 10, array addresses whose top address bit is 0 (the lowest half) are rejected, and the upper half is accepted.
- R5: With code 11, every array write is rejected.
- R6: While the lock bit is 1, register writes to addresses 0x11 through 0x18 inclusive are rejected. Addresses 0x10 and 0x19 stay writable.
- R7: Once the lock bit is 1, no write returns it to 0. Only reset clears it.
- R8: A register write to address 0x0B (the control register) is always accepted. It loads the protection code from data bits [1:0] and ORs data bit 7 into the lock bit. The new code governs requests from the next one onward.
- R9: The protection code has no effect on register-space writes. The lock bit has no effect on array writes.
- R10: After reset, the code is 00, the lock bit is 0 and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request strobe, one cycle per request |
| req_space | input | 1 | Target: 0 = array, 1 = register space |
| req_addr | input | ARRAY_AW (10) | Address; register space uses the low REG_AW (8) bits |
| req_wdata | input | DW (8) | Write data |
| arr_we | output | 1 | Accepted array write pulse |
| reg_we | output | 1 | Accepted register write pulse |
| wr_reject | output | 1 | Rejected write pulse |
| wr_addr | output | ARRAY_AW (10) | Registered address of the last request |
| wr_data | output | DW (8) | Registered data of the last request |
| cfg_wp | output | 2 | Current protection code |
| cfg_lock | output | 1 | Current lock bit |

## Verification
The assertions check several rules on every cycle:
- the single-outcome rule;
- rejection for each guarded region, using the code that was current when the request arrived;
- rejection inside the locked window;
- stickiness of the lock bit;
- unconditional acceptance of control-register writes.

Other behaviours need the bench's ordered scenarios to show them:
- exact region boundaries (the last guarded and first free address for each code);
- a code change governing the very next request;
- a control write with bit 7 clear leaving the lock set while still changing the code.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

  typedef enum logic {
    SPACE_ARRAY = 1'b0,
    SPACE_REG   = 1'b1
  } space_e;

  typedef enum logic [1:0] {
    WP_NONE    = 2'b00,
    WP_QUARTER = 2'b01,
    WP_HALF    = 2'b10,
    WP_ALL     = 2'b11
  } wp_code_e;

  // Guard decision from the protection code and the top two address bits.
  function automatic logic region_guarded(input logic [1:0] code,
                                          input logic [1:0] top2);
    logic g;
    case (code)
      WP_NONE:    g = 1'b0;
      WP_QUARTER: g = (top2 == 2'b00);
      WP_HALF:    g = ~top2[1];
      default:    g = 1'b1;
    endcase
    return g;
  endfunction

  // Inclusive window membership on a register address.
  function automatic logic in_window(input logic [15:0] a,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/wp_region_dec.sv
module wp_region_dec
  import wp_guard_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [1:0]    wp_code,
  input  logic [AW-1:0] addr,
  output logic          guarded
);
  localparam int TOP = AW - 1;

  logic [1:0] top2;

  generate
    if (AW >= 2) begin : g_wide
      assign top2 = addr[TOP -: 2];
    end else begin : g_narrow
      assign top2 = {addr[0], 1'b0};
    end
  endgenerate

  assign guarded = region_guarded(wp_code, top2);
endmodule

// File: rtl/wp_reg_decode.sv
module wp_reg_decode
  import wp_guard_pkg::*;
#(
  parameter int          RAW      = 8,
  parameter logic [15:0] CTRL_ADR = 16'h000B,
  parameter logic [15:0] LOCK_LO  = 16'h0011,
  parameter logic [15:0] LOCK_HI  = 16'h0018
) (
  input  logic [RAW-1:0] addr,
  input  logic           lock,
  output logic           is_ctrl,
  output logic           sealed
);
  logic [15:0] a_ext;

  assign a_ext   = 16'(addr);
  assign is_ctrl = (a_ext == CTRL_ADR);
  assign sealed  = lock & in_window(a_ext, LOCK_LO, LOCK_HI);
endmodule

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs #(
  parameter int DW       = 8,
  parameter int LOCK_BIT = 7,
  parameter int WP_LSB   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [DW-1:0] wdata,
  output logic [1:0]    wp_code,
  output logic          lock
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_code <= 2'b00;
      lock    <= 1'b0;
    end else if (ctrl_we) begin
      wp_code <= wdata[WP_LSB +: 2];
      lock    <= lock | wdata[LOCK_BIT];
    end
  end
endmodule

// File: rtl/wp_guard_ctrl.sv
module wp_guard_ctrl
  import wp_guard_pkg::*;
#(
  parameter int          ARRAY_AW = 10,
  parameter int          REG_AW   = 8,
  parameter int          DW       = 8,
  parameter int          LOCK_BIT = 7,
  parameter int          WP_LSB   = 0,
  parameter logic [15:0] CTRL_ADR = 16'h000B,
  parameter logic [15:0] LOCK_LO  = 16'h0011,
  parameter logic [15:0] LOCK_HI  = 16'h0018
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_space,
  input  logic [ARRAY_AW-1:0] req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                arr_we,
  output logic                reg_we,
  output logic                wr_reject,
  output logic [ARRAY_AW-1:0] wr_addr,
  output logic [DW-1:0]       wr_data,
  output logic [1:0]          cfg_wp,
  output logic                cfg_lock
);
  // Named internal events
  logic arr_req, reg_req;
  logic arr_guarded, reg_is_ctrl, reg_sealed;
  logic arr_block, reg_block, ctrl_we;
  logic arr_ok, reg_ok;

  assign arr_req = req_valid & (req_space == SPACE_ARRAY);
  assign reg_req = req_valid & (req_space == SPACE_REG);

  wp_region_dec #(.AW(ARRAY_AW)) u_region (
    .wp_code (cfg_wp),
    .addr    (req_addr),
    .guarded (arr_guarded)
  );

  wp_reg_decode #(
    .RAW      (REG_AW),
    .CTRL_ADR (CTRL_ADR),
    .LOCK_LO  (LOCK_LO),
    .LOCK_HI  (LOCK_HI)
  ) u_regdec (
    .addr    (req_addr[REG_AW-1:0]),
    .lock    (cfg_lock),
    .is_ctrl (reg_is_ctrl),
    .sealed  (reg_sealed)
  );

  assign arr_block = arr_req & arr_guarded;
  assign reg_block = reg_req & reg_sealed & ~reg_is_ctrl;
  assign arr_ok    = arr_req & ~arr_guarded;
  assign reg_ok    = reg_req & ~reg_block;
  assign ctrl_we   = reg_ok & reg_is_ctrl;

  wp_cfg_regs #(
    .DW       (DW),
    .LOCK_BIT (LOCK_BIT),
    .WP_LSB   (WP_LSB)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_we (ctrl_we),
    .wdata   (req_wdata),
    .wp_code (cfg_wp),
    .lock    (cfg_lock)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_we    <= 1'b0;
      reg_we    <= 1'b0;
      wr_reject <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      arr_we    <= arr_ok;
      reg_we    <= reg_ok;
      wr_reject <= arr_block | reg_block;
      if (req_valid) begin
        wr_addr <= req_addr;
        wr_data <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int          AW       = 10,
  parameter int          RAW      = 8,
  parameter logic [15:0] CTRL_ADR = 16'h000B,
  parameter logic [15:0] LOCK_LO  = 16'h0011,
  parameter logic [15:0] LOCK_HI  = 16'h0018
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_space,
  input logic [AW-1:0] req_addr,
  input logic          arr_we,
  input logic          reg_we,
  input logic          wr_reject,
  input logic [1:0]    cfg_wp,
  input logic          cfg_lock
);
  logic [15:0] ra;
  logic        arr_q, reg_q;

  assign ra    = 16'(req_addr[RAW-1:0]);
  assign arr_q = req_valid & ~req_space;
  assign reg_q = req_valid & req_space;

  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ($countones({arr_we, reg_we, wr_reject}) == 1));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ({arr_we, reg_we, wr_reject} == 3'b000));

  assert_open_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_q && cfg_wp == 2'b00) |=> arr_we);

  assert_quarter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_q && cfg_wp == 2'b01 && req_addr[AW-1 -: 2] == 2'b00) |=> wr_reject);

  assert_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_q && cfg_wp == 2'b10 && !req_addr[AW-1]) |=> wr_reject);

  assert_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_q && cfg_wp == 2'b11) |=> wr_reject);

  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q && cfg_lock && ra >= LOCK_LO && ra <= LOCK_HI) |=> wr_reject);

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> cfg_lock);

  assert_ctrl_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q && ra == CTRL_ADR) |=> reg_we);

  assert_regs_ignore_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q && !cfg_lock) |=> reg_we);
endmodule

bind wp_guard_ctrl wp_guard_chk #(
  .AW       (ARRAY_AW),
  .RAW      (REG_AW),
  .CTRL_ADR (CTRL_ADR),
  .LOCK_LO  (LOCK_LO),
  .LOCK_HI  (LOCK_HI)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_space (req_space),
  .req_addr  (req_addr),
  .arr_we    (arr_we),
  .reg_we    (reg_we),
  .wr_reject (wr_reject),
  .cfg_wp    (cfg_wp),
  .cfg_lock  (cfg_lock)
);

// File: tb/wp_guard_ctrl_tb.sv
module wp_guard_ctrl_tb;
  localparam int AW   = 10;
  localparam int DW   = 8;
  localparam int SIZE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_space = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          arr_we, reg_we, wr_reject;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0]    cfg_wp;
  logic          cfg_lock;

  int checks = 0;
  int failures = 0;

  // Behavioural reference state
  int m_code = 0;
  int m_lock = 0;

  always #10 clk = ~clk;

  wp_guard_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
    .req_addr(req_addr), .req_wdata(req_wdata), .arr_we(arr_we), .reg_we(reg_we),
    .wr_reject(wr_reject), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_wp(cfg_wp), .cfg_lock(cfg_lock)
  );

  task automatic compare(input string tag, input int e_arr, input int e_reg,
                         input int e_rej, input int e_addr, input int e_data,
                         input int chk_bus);
    int bad;
    checks++;
    bad = (int'(arr_we) != e_arr) || (int'(reg_we) != e_reg) ||
          (int'(wr_reject) != e_rej) || (int'(cfg_wp) != m_code) ||
          (int'(cfg_lock) != m_lock);
    if (chk_bus != 0)
      bad = bad || (int'(wr_addr) != e_addr) || (int'(wr_data) != e_data);
    if (bad != 0) begin
      failures++;
      $display("FAIL %s actual arr=%0d reg=%0d rej=%0d wp=%0d lock=%0d addr=%0h data=%0h expected arr=%0d reg=%0d rej=%0d wp=%0d lock=%0d addr=%0h data=%0h",
               tag, arr_we, reg_we, wr_reject, cfg_wp, cfg_lock, wr_addr, wr_data,
               e_arr, e_reg, e_rej, m_code, m_lock, e_addr, e_data);
    end
  endtask

  // One clock of stimulus; the result is compared after the following edge.
  task automatic step(input string tag, input int v, input int sp,
                      input int addr, input int data);
    int e_arr, e_reg, e_rej, limit, ra;
    @(negedge clk);
    req_valid = v[0];
    req_space = sp[0];
    req_addr  = AW'(addr);
    req_wdata = DW'(data);
    e_arr = 0; e_reg = 0; e_rej = 0;
    if (v != 0) begin
      if (sp == 0) begin
        limit = (m_code == 3) ? SIZE : (m_code * SIZE) / 4;
        if (addr < limit) e_rej = 1; else e_arr = 1;
      end else begin
        ra = addr % 256;
        if (ra != 11 && m_lock == 1 && ra >= 17 && ra <= 24) e_rej = 1;
        else e_reg = 1;
        if (ra == 11) begin
          m_code = data % 4;
          if (((data >> 7) & 1) == 1) m_lock = 1;
        end
      end
    end
    @(posedge clk);
    #2;
    compare(tag, e_arr, e_reg, e_rej, addr, data, v);
    req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual hung expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare("R10 reset state", 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    rst_n = 1'b1;

    step("R1 idle cycle", 0, 0, 0, 0);
    step("R2 code00 addr0", 1, 0, 0, 8'h5A);
    step("R2 code00 top addr", 1, 0, SIZE - 1, 8'hA5);

    step("R8 set code01", 1, 1, 11, 8'h01);
    step("R3 quarter last guarded", 1, 0, SIZE / 4 - 1, 8'h11);
    step("R3 quarter first free", 1, 0, SIZE / 4, 8'h12);
    step("R1 idle after reject", 0, 0, 0, 0);

    step("R8 set code10", 1, 1, 11, 8'h02);
    step("R4 half low edge", 1, 0, 0, 8'h21);
    step("R4 half last guarded", 1, 0, SIZE / 2 - 1, 8'h22);
    step("R4 half first free", 1, 0, SIZE / 2, 8'h23);

    step("R8 set code11", 1, 1, 11, 8'h03);
    step("R5 full top", 1, 0, SIZE - 1, 8'h31);
    step("R5 full mid", 1, 0, SIZE / 2, 8'h32);
    step("R9 reg write under code11", 1, 1, 17, 8'h33);

    step("R8 set lock keep code11", 1, 1, 11, 8'h83);
    step("R6 window low edge", 1, 1, 17, 8'h41);
    step("R6 window high edge", 1, 1, 24, 8'h42);
    step("R6 below window", 1, 1, 16, 8'h43);
    step("R6 above window", 1, 1, 25, 8'h44);

    step("R7 clear attempt code00", 1, 1, 11, 8'h00);
    step("R8 new code next request", 1, 0, 0, 8'h51);
    step("R9 lock ignores array", 1, 0, SIZE - 1, 8'h52);
    step("R6 still sealed", 1, 1, 20, 8'h53);
    step("R8 code01 while locked", 1, 1, 11, 8'h01);
    step("R3 quarter while locked", 1, 0, 5, 8'h54);
    step("R1 final idle", 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule